// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block watches a battery-backed byte-wide memory through four digital supply-level flags and decides, cycle by cycle, whether the memory may be accessed. When the supply sags it blocks writes and tristates the data side. When the supply collapses it hands the memory over to the backup cell. When the supply returns it holds the memory locked for a programmable recovery delay before it allows normal access again. The comparators, the battery and the array are outside the block. Only the sequencing and the timing are inside it.

A new part leaves assembly with its backup cell electrically isolated, so that the cell keeps its full charge. The isolation is released the first time the supply is seen above the seal-release level. After that release the backup path is armed for good, and only a reset clears it. A strap input chooses one of two tolerance variants. The variant moves both the write-protect trip point and the full-function threshold by one comparator level. A free-running millisecond tick sets the pace of the recovery delay.

Top module: `pf_guard_seq`

## Requirements
- R1: While `rst` is high, and right after it is released, the outputs are `wr_block_o`=1, `io_hiz_o`=1, `bat_sel_o`=0 and `seal_done_o`=0 (the sealed state).
- R2: Each bit of `lvl_i` passes two synchronizer flops. A new value is accepted only once two consecutive synchronized samples agree, so a level held for at least two cycles takes effect and a one-cycle pulse is ignored.
- R3: `seal_done_o` rises once the accepted `lvl_i[1]` (above the seal-release level) is 1. It never falls again until reset.
- R4: `bat_sel_o` is 1 exactly when the seal has been released and the accepted `lvl_i[0]` (above the switchover level) is 0. Before the release it stays 0 at every supply level.
- R5: `wr_block_o` and `io_hiz_o` are both 1 in every state other than normal operation, and both are 0 in normal operation.
- R6: With `tol_narrow_i`=1 the full-function flag is `lvl_i[3]` and the trip flag is `lvl_i[2]`. With `tol_narrow_i`=0 the full-function flag is `lvl_i[2]` and the trip flag is `lvl_i[1]`.
- R7: Normal operation is entered only from recovery. Recovery begins when the accepted full-function flag is 1. Normal operation begins on the tick that brings the number of ticks counted in recovery up to the effective delay.
- R8: The effective delay in ticks is `rec_ms_i` clamped to the range 2 to 125.
- R9: If the full-function flag drops during recovery, the block returns to the protected state and clears the tick count, so the whole delay starts over.
- R10: Normal operation continues while the trip flag stays 1, even when the full-function flag is 0. When the trip flag falls, the block enters the protected state.
- R11: Once the seal is released, an accepted switchover flag of 0 moves the block from any state to backup. When the flag returns to 1, the block goes from backup to protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; models first assembly |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| tol_narrow_i | input | 1 | Tolerance variant strap (1 = narrow band) |
| rec_ms_i | input | 7 | Requested recovery delay in ticks |
| lvl_i | input | 4 | Supply comparator flags: bit0 >3.0 V, bit1 >4.25 V, bit2 >4.5 V, bit3 >4.75 V |
| wr_block_o | output | 1 | Memory writes blocked |
| io_hiz_o | output | 1 | Memory inputs ignored and data outputs tristated |
| bat_sel_o | output | 1 | Backup source powers the memory |
| seal_done_o | output | 1 | Sticky flag: backup cell has been released |

## Verification
Supply ramps are driven up and down under both tolerance variants. These ramps separate the two threshold pairs: a level between the trip and full-function points keeps normal operation alive but never starts recovery. A ramp that crosses the switchover level before the seal is released, together with one-cycle pulses on a flag, shows that the sealed state and the input filter hold firm. A dip during recovery and delays requested at 0, 5 and 127 show that the timer restarts and that the requested delay is clamped. A behavioural model predicts every output on every clock.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int NUM_LVL  = 4;
    localparam int LVL_SW   = 0;   // above switchover level
    localparam int LVL_SEAL = 1;   // above seal-release level
    localparam int LVL_MID  = 2;
    localparam int LVL_TOP  = 3;

    typedef enum logic [2:0] {
        ST_SEALED  = 3'd0,
        ST_BACKUP  = 3'd1,
        ST_PROTECT = 3'd2,
        ST_RECOVER = 3'd3,
        ST_NORMAL  = 3'd4
    } pfg_state_e;

    typedef struct packed {
        pfg_state_e state;
        logic       seal;
    } pfg_ctl_t;

endpackage

// File: rtl/pfg_level_filter.sv
module pfg_level_filter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] clean_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
        logic [N-1:0] acc;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.s1   = raw_i;
        f_d.s2   = f_q.s1;
        f_d.prev = f_q.s2;
        for (int i = 0; i < N; i++) begin
            if (f_q.s2[i] == f_q.prev[i]) begin
                f_d.acc[i] = f_q.s2[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign clean_o = f_q.acc;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2
        filter_agree_chk: assert property (@(posedge clk) disable iff (rst)
            (clean_o[g] != $past(clean_o[g])) |-> ($past(raw_i[g], 3) == $past(raw_i[g], 4)))
            else $error("filter accepted a flag without two agreeing samples");
    end

endmodule

// File: rtl/pfg_recovery_timer.sv
module pfg_recovery_timer #(
    parameter int LIM_W   = 7,
    parameter int LIM_MIN = 2,
    parameter int LIM_MAX = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             clear_i,
    input  logic             step_i,
    output logic             done_o
);

    localparam logic [LIM_W-1:0] MIN_V = LIM_W'(LIM_MIN);
    localparam logic [LIM_W-1:0] MAX_V = LIM_W'(LIM_MAX);

    logic [LIM_W-1:0] cnt_d, cnt_q;
    logic [LIM_W-1:0] lim_eff;
    logic [LIM_W:0]   cnt_inc;

    always_comb begin
        if (limit_i < MIN_V) begin
            lim_eff = MIN_V;
        end else if (limit_i > MAX_V) begin
            lim_eff = MAX_V;
        end else begin
            lim_eff = limit_i;
        end
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        done_o  = step_i && (cnt_inc >= {1'b0, lim_eff});
        cnt_d   = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i && !done_o) begin
            cnt_d = cnt_inc[LIM_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8
    timer_max_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < MAX_V)
        else $error("recovery count passed the clamp ceiling");

    // R9
    timer_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_q == '0))
        else $error("recovery count not cleared");

endmodule

// File: rtl/pf_guard_seq.sv
module pf_guard_seq
    import pfg_pkg::*;
#(
    parameter int LIM_W   = 7,
    parameter int LIM_MIN = 2,
    parameter int LIM_MAX = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms_i,
    input  logic             tol_narrow_i,
    input  logic [LIM_W-1:0] rec_ms_i,
    input  logic [3:0]       lvl_i,
    output logic             wr_block_o,
    output logic             io_hiz_o,
    output logic             bat_sel_o,
    output logic             seal_done_o
);

    logic [NUM_LVL-1:0] lvl_ok;
    logic               f_sw, f_seal, f_full, f_trip;
    logic               t_clear, t_step, t_done;
    pfg_ctl_t           ctl_d, ctl_q;

    pfg_level_filter #(.N(NUM_LVL)) i_filter (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (lvl_i),
        .clean_o (lvl_ok)
    );

    assign f_sw   = lvl_ok[LVL_SW];
    assign f_seal = lvl_ok[LVL_SEAL];
    assign f_full = tol_narrow_i ? lvl_ok[LVL_TOP] : lvl_ok[LVL_MID];
    assign f_trip = tol_narrow_i ? lvl_ok[LVL_MID] : lvl_ok[LVL_SEAL];

    assign t_clear = (ctl_q.state != ST_RECOVER);
    assign t_step  = (ctl_q.state == ST_RECOVER) && tick_ms_i && f_full && f_sw;

    pfg_recovery_timer #(
        .LIM_W   (LIM_W),
        .LIM_MIN (LIM_MIN),
        .LIM_MAX (LIM_MAX)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .limit_i (rec_ms_i),
        .clear_i (t_clear),
        .step_i  (t_step),
        .done_o  (t_done)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.seal = ctl_q.seal | f_seal;
        unique case (ctl_q.state)
            ST_SEALED: begin
                if (f_seal) ctl_d.state = ST_PROTECT;
            end
            ST_BACKUP: begin
                if (f_sw) ctl_d.state = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!f_sw)       ctl_d.state = ST_BACKUP;
                else if (f_full) ctl_d.state = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (!f_sw)        ctl_d.state = ST_BACKUP;
                else if (!f_full) ctl_d.state = ST_PROTECT;
                else if (t_done)  ctl_d.state = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (!f_sw)        ctl_d.state = ST_BACKUP;
                else if (!f_trip) ctl_d.state = ST_PROTECT;
            end
            default: ctl_d.state = ST_SEALED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_SEALED, seal: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_block_o  = (ctl_q.state != ST_NORMAL);
    assign io_hiz_o    = (ctl_q.state != ST_NORMAL);
    assign bat_sel_o   = (ctl_q.state == ST_BACKUP);
    assign seal_done_o = ctl_q.seal;

    // R3
    seal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        seal_done_o |=> seal_done_o)
        else $error("seal flag reverted");

    // R4
    backup_needs_seal_chk: assert property (@(posedge clk) disable iff (rst)
        bat_sel_o |-> seal_done_o)
        else $error("backup selected while sealed");

    // R5
    access_needs_seal_chk: assert property (@(posedge clk) disable iff (rst)
        !io_hiz_o |-> seal_done_o)
        else $error("access opened before seal release");

    // R7
    normal_via_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state != ST_NORMAL && ctl_q.state != ST_RECOVER) |=> ctl_q.state != ST_NORMAL)
        else $error("normal entered without recovery");

    // R11
    backup_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.seal && !f_sw && ctl_q.state != ST_SEALED) |=> bat_sel_o)
        else $error("backup not selected below switchover");

endmodule

// File: tb/test_pf_guard_seq.sv
module test_pf_guard_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       tol_narrow = 1'b1;
    logic [6:0] rec_ms = 7'd5;
    logic [3:0] lvl = 4'b0000;
    logic       wr_block, io_hiz, bat_sel, seal_done;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase_req = "R1";

    always #5 clk = ~clk;

    pf_guard_seq i_pf_guard_seq (
        .clk          (clk),
        .rst          (rst),
        .tick_ms_i    (tick),
        .tol_narrow_i (tol_narrow),
        .rec_ms_i     (rec_ms),
        .lvl_i        (lvl),
        .wr_block_o   (wr_block),
        .io_hiz_o     (io_hiz),
        .bat_sel_o    (bat_sel),
        .seal_done_o  (seal_done)
    );

    // millisecond tick, compressed to one pulse every four cycles
    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % 4;
        tick <= (tick_cnt == 0);
    end

    // behavioural reference model
    typedef enum int {M_SEALED, M_BACKUP, M_PROTECT, M_RECOVER, M_NORMAL} mstate_t;
    mstate_t m_state = M_SEALED;
    bit      m_seal = 0;
    int      m_ticks = 0;
    bit [3:0] m_seen = 4'b0;
    bit [3:0] hist[$];

    function automatic int eff_limit(int req);
        if (req < 2) return 2;
        if (req > 125) return 125;
        return req;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_state = M_SEALED;
            m_seal  = 0;
            m_ticks = 0;
            m_seen  = 4'b0;
            hist    = '{4'b0, 4'b0, 4'b0, 4'b0};
        end else begin
            bit sw, sl, full, trip;
            sw   = m_seen[0];
            sl   = m_seen[1];
            full = tol_narrow ? m_seen[3] : m_seen[2];
            trip = tol_narrow ? m_seen[2] : m_seen[1];
            m_seal = m_seal | sl;
            case (m_state)
                M_SEALED:  if (sl) m_state = M_PROTECT;
                M_BACKUP:  if (sw) m_state = M_PROTECT;
                M_PROTECT: begin
                    m_ticks = 0;
                    if (!sw) m_state = M_BACKUP;
                    else if (full) m_state = M_RECOVER;
                end
                M_RECOVER: begin
                    if (!sw) begin m_state = M_BACKUP; m_ticks = 0; end
                    else if (!full) begin m_state = M_PROTECT; m_ticks = 0; end
                    else if (tick) begin
                        if (m_ticks + 1 >= eff_limit(int'(rec_ms))) begin
                            m_state = M_NORMAL;
                            m_ticks = 0;
                        end else begin
                            m_ticks++;
                        end
                    end
                end
                M_NORMAL: begin
                    if (!sw) m_state = M_BACKUP;
                    else if (!trip) m_state = M_PROTECT;
                end
                default: m_state = M_SEALED;
            endcase
            // flag acceptance: two agreeing synchronized samples
            hist.push_back(lvl);
            while (hist.size() > 4) void'(hist.pop_front());
            for (int b = 0; b < 4; b++) begin
                if (hist[1][b] == hist[0][b]) m_seen[b] = hist[1][b];
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_lock;
            exp_lock = (m_state != M_NORMAL);
            chk(wr_block == exp_lock, {"R5/", phase_req}, "wr_block model", wr_block, exp_lock);
            chk(io_hiz == exp_lock, {"R5/", phase_req}, "io_hiz model", io_hiz, exp_lock);
            chk(bat_sel == (m_state == M_BACKUP), {"R4/", phase_req}, "bat_sel model",
                bat_sel, m_state == M_BACKUP);
            chk(seal_done == m_seal, {"R3/", phase_req}, "seal_done model", seal_done, m_seal);
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(string req, int wb, int bs, int sd);
        chk(wr_block == wb, req, "wr_block", wr_block, wb);
        chk(io_hiz == wb, req, "io_hiz", io_hiz, wb);
        chk(bat_sel == bs, req, "bat_sel", bat_sel, bs);
        chk(seal_done == sd, req, "seal_done", seal_done, sd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        // R1: outputs held during reset
        expect_out("R1", 1, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1", 1, 0, 0);

        // R4: supply above switchover and back to zero while still sealed
        phase_req = "R4";
        lvl = 4'b0001; wait_cyc(10);
        expect_out("R4", 1, 0, 0);
        lvl = 4'b0000; wait_cyc(10);
        expect_out("R4", 1, 0, 0);

        // R2: one-cycle pulses on the seal-release flag are ignored
        phase_req = "R2";
        lvl = 4'b0001; wait_cyc(6);
        lvl = 4'b0011; wait_cyc(1);
        lvl = 4'b0001; wait_cyc(3);
        lvl = 4'b0011; wait_cyc(1);
        lvl = 4'b0001; wait_cyc(8);
        expect_out("R2", 1, 0, 0);

        // R3: seal released once the level is held
        phase_req = "R3";
        lvl = 4'b0011; wait_cyc(2);
        expect_out("R2", 1, 0, 0);
        wait_cyc(6);
        expect_out("R3", 1, 0, 1);

        // R6: narrow variant, 4.5 V is not full-function
        phase_req = "R6";
        tol_narrow = 1'b1; rec_ms = 7'd5;
        lvl = 4'b0111; wait_cyc(40);
        expect_out("R6", 1, 0, 1);

        // R7: full-function reached, delay of 5 ticks
        phase_req = "R7";
        lvl = 4'b1111; wait_cyc(10);
        expect_out("R7", 1, 0, 1);
        wait_cyc(30);
        expect_out("R7", 0, 0, 1);

        // R10: between trip and full keeps access, below trip drops it
        phase_req = "R10";
        lvl = 4'b0111; wait_cyc(12);
        expect_out("R10", 0, 0, 1);
        lvl = 4'b0011; wait_cyc(8);
        expect_out("R10", 1, 0, 1);

        // R9: dip during recovery restarts the delay
        phase_req = "R9";
        lvl = 4'b1111; wait_cyc(14);
        lvl = 4'b0111; wait_cyc(8);
        expect_out("R9", 1, 0, 1);
        lvl = 4'b1111; wait_cyc(14);
        expect_out("R9", 1, 0, 1);
        wait_cyc(30);
        expect_out("R9", 0, 0, 1);

        // R11: collapse to backup, seal stays
        phase_req = "R11";
        lvl = 4'b0000; wait_cyc(8);
        expect_out("R11", 1, 1, 1);
        expect_out("R3", 1, 1, 1);

        // R8: wide variant, request 0 clamps to 2
        phase_req = "R8";
        tol_narrow = 1'b0; rec_ms = 7'd0;
        lvl = 4'b0111; wait_cyc(6);
        expect_out("R8", 1, 0, 1);
        wait_cyc(14);
        expect_out("R8", 0, 0, 1);

        // R6: wide variant keeps access above 4.25 V
        phase_req = "R6";
        lvl = 4'b0011; wait_cyc(10);
        expect_out("R6", 0, 0, 1);
        lvl = 4'b0001; wait_cyc(10);
        expect_out("R6", 1, 0, 1);

        // R8: request 127 clamps to 125
        phase_req = "R8";
        rec_ms = 7'd127;
        lvl = 4'b0111; wait_cyc(400);
        expect_out("R8", 1, 0, 1);
        wait_cyc(160);
        expect_out("R8", 0, 0, 1);

        // R11: backup from normal, then back to protected on return
        phase_req = "R11";
        lvl = 4'b0000; wait_cyc(8);
        expect_out("R11", 1, 1, 1);
        lvl = 4'b0001; wait_cyc(8);
        expect_out("R11", 1, 0, 1);

        wait_cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule